// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block sits on the path from a bus master to a word-addressed memory or register space. It lets the master treat any single bit of two 1 MB backing areas (an SRAM area based at 0x20000000 and a peripheral area based at 0x40000000) as if that bit were a full 32-bit word. Each backing area has a 32 MB alias window (at 0x22000000 and 0x42000000). Every alias word stands for exactly one bit of the backing area.

Addresses outside both alias windows go through untouched. An alias read becomes one slave read of the backing word, and the addressed bit is returned alone. An alias write becomes a locked read-modify-write of the backing word. The lock output is raised for both phases, so no other traffic can slip between the read and the write.

Both ports use a request/ready handshake. A transfer completes in the cycle where request and ready are both high. Read data is valid in that cycle. The master holds its request fields stable until it sees ready.

Top module: `bitband_xlate`

## Requirements
- R1: An address outside both alias windows is forwarded unchanged to the slave with the same direction and write data. It takes exactly one slave transfer, and read data returns unchanged.
- R2: An address in 0x22000000–0x23FFFFFF maps to backing word address 0x20000000 + ((offset / 32) rounded down to a multiple of 4), where offset = address − 0x22000000. The bit index is offset bits 6:2, which equals (offset mod 32)/4 + 8 × (byte address mod 4).
- R3: An address in 0x42000000–0x43FFFFFF maps in the same way onto the backing area based at 0x40000000.
- R4: An alias read performs exactly one slave read of the backing word. It returns the addressed bit in bit 0 and zeros in bits 31:1.
- R5: An alias write performs exactly two slave transfers, a read then a write, both at the backing word address. The written word equals the word read with only the addressed bit replaced by bit 0 of the master's write data.
- R6: On an alias write, bits 31:1 of the master's write data have no effect on the stored word.
- R7: During both phases of an alias write, the lock output is high and master ready stays low until the write phase is accepted. The lock output is low for pass-through traffic.
- R8: After reset with the master idle, the slave request and lock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master transfer request |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Master transfer completes this cycle |
| m_rdata | output | 32 | Read data to the master |
| s_req | output | 1 | Slave transfer request |
| s_we | output | 1 | Slave write (1) or read (0) |
| s_addr | output | 32 | Slave word address |
| s_wdata | output | 32 | Slave write data |
| s_lock | output | 1 | Keeps the slave path locked for a read-modify-write |
| s_ready | input | 1 | Slave accepts the transfer this cycle |
| s_rdata | input | 32 | Slave read data, valid with s_ready |

## Verification
Pass-through transfers and alias reads are combinational paths, so their master ready and read data appear in the same cycle as the slave's ready. The bench samples them one nanosecond after driving, before the completing edge.

An alias write finishes one registered step after its read phase is accepted, at the earliest. The bench therefore keeps polling master ready each cycle, and checks that it stays low while the read phase is on the slave port.

Slave handshakes are recorded at each clock edge and compared after the master's transfer closes. Slave wait states are inserted in some runs, so that phases stretched over many cycles are covered too.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int GRAN_LOG2  = $clog2(DATA_W / 8);
  localparam int ALIAS_LOG2 = 25;
  localparam int N_REG      = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // index 0: SRAM area, index 1: peripheral area
  localparam addr_t BAND_BASE  [N_REG] = '{32'h2000_0000, 32'h4000_0000};
  localparam addr_t ALIAS_BASE [N_REG] = '{32'h2200_0000, 32'h4200_0000};

  typedef enum logic {PH_IDLE, PH_WRITE} rmw_ph_e;
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
  import bb_pkg::*;
(
  input  addr_t            addr,
  output logic             hit,
  output addr_t            word_addr,
  output logic [BIT_W-1:0] bit_idx
);
  localparam int LOW_W = BIT_W + GRAN_LOG2;
  localparam int PAD_W = ADDR_W - ALIAS_LOG2 + BIT_W;

  logic [N_REG-1:0]      hit_r;
  logic [ALIAS_LOG2-1:0] off;
  addr_t                 base_sel;

  for (genvar r = 0; r < N_REG; r++) begin : g_region
    assign hit_r[r] = (addr[ADDR_W-1:ALIAS_LOG2] == ALIAS_BASE[r][ADDR_W-1:ALIAS_LOG2]);
  end

  always_comb begin
    base_sel = '0;
    for (int r = 0; r < N_REG; r++) begin
      if (hit_r[r]) base_sel = base_sel | BAND_BASE[r];
    end
  end

  assign hit       = |hit_r;
  assign off       = addr[ALIAS_LOG2-1:0];
  // one alias word per backing bit: drop the bit-in-word field, keep word alignment
  assign word_addr = base_sel | {{PAD_W{1'b0}}, off[ALIAS_LOG2-1:LOW_W], {GRAN_LOG2{1'b0}}};
  assign bit_idx   = off[LOW_W-1:GRAN_LOG2];
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  data_t            word,
  input  logic [BIT_W-1:0] idx,
  input  logic             val,
  output data_t            merged,
  output logic             sel_bit
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = (idx == BIT_W'(i)) ? val : word[i];
  end
  assign sel_bit = word[idx];
endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
  import bb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rd_accept,
  input  logic    wr_accept,
  input  data_t   merged,
  output rmw_ph_e ph,
  output data_t   held_word
);
  rmw_ph_e ph_nx;
  logic    word_en;

  always_comb begin
    ph_nx   = ph;
    word_en = 1'b0;
    case (ph)
      PH_IDLE: if (rd_accept) begin
        ph_nx   = PH_WRITE;
        word_en = 1'b1;
      end
      PH_WRITE: if (wr_accept) ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nx;
  end

  always_ff @(posedge clk) begin
    if (word_en) held_word <= merged;
  end
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        m_req,
  input  logic        m_we,
  input  logic [31:0] m_addr,
  input  logic [31:0] m_wdata,
  output logic        m_ready,
  output logic [31:0] m_rdata,
  output logic        s_req,
  output logic        s_we,
  output logic [31:0] s_addr,
  output logic [31:0] s_wdata,
  output logic        s_lock,
  input  logic        s_ready,
  input  logic [31:0] s_rdata
);
  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic             hit;
  addr_t            word_addr;
  logic [BIT_W-1:0] bit_idx;
  data_t            merged;
  data_t            held_word;
  logic             sel_bit;
  rmw_ph_e          ph;
  logic             rd_accept;
  logic             wr_accept;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  bb_alias_decode i_dec (
    .addr      (m_addr),
    .hit       (hit),
    .word_addr (word_addr),
    .bit_idx   (bit_idx)
  );

  bb_bit_merge i_merge (
    .word    (s_rdata),
    .idx     (bit_idx),
    .val     (m_wdata[0]),
    .merged  (merged),
    .sel_bit (sel_bit)
  );

  assign rd_accept = (ph == PH_IDLE) && m_req && m_we && hit && s_ready;
  assign wr_accept = (ph == PH_WRITE) && s_ready;

  bb_rmw_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rd_accept (rd_accept),
    .wr_accept (wr_accept),
    .merged    (merged),
    .ph        (ph),
    .held_word (held_word)
  );

  always_comb begin
    s_req   = m_req;
    s_we    = m_we;
    s_addr  = m_addr;
    s_wdata = m_wdata;
    s_lock  = 1'b0;
    m_ready = s_ready;
    m_rdata = s_rdata;
    if (ph == PH_WRITE) begin
      s_req   = 1'b1;
      s_we    = 1'b1;
      s_addr  = word_addr;
      s_wdata = held_word;
      s_lock  = 1'b1;
      m_rdata = '0;
    end else if (m_req && hit) begin
      s_addr  = word_addr;
      m_rdata = {{(DATA_W-1){1'b0}}, sel_bit};
      if (m_we) begin
        s_we    = 1'b0;
        s_lock  = 1'b1;
        m_ready = 1'b0;
        m_rdata = '0;
      end
    end
  end
endmodule

// File: rtl/bb_xlate_chk.sv
module bb_xlate_chk
  import bb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        m_req,
  input logic        m_we,
  input logic [31:0] m_addr,
  input logic        m_ready,
  input logic [31:0] m_rdata,
  input logic        s_req,
  input logic        s_we,
  input logic [31:0] s_addr,
  input logic [31:0] s_wdata,
  input logic        s_lock,
  input logic        s_ready,
  input logic [31:0] s_rdata
);
  logic in_alias;
  logic rd_phase_done;

  assign in_alias = (m_addr[31:ALIAS_LOG2] == ALIAS_BASE[0][31:ALIAS_LOG2]) ||
                    (m_addr[31:ALIAS_LOG2] == ALIAS_BASE[1][31:ALIAS_LOG2]);
  assign rd_phase_done = s_req && s_lock && !s_we && s_ready;

  // R5, R7: a locked read phase is followed by a locked write phase
  a_r5_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase_done |=> (s_req && s_we && s_lock));

  // R5: both phases use the same word address
  a_r5_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase_done |=> (s_addr == $past(s_addr)));

  // R5: the first write cycle changes at most one bit of the word read
  a_r5_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase_done |=> ($countones(s_wdata ^ $past(s_rdata)) <= 1));

  // R7: no completion to the master while the locked read is on the slave port
  a_r7_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && s_lock && !s_we) |-> !m_ready);

  // R7, R1: pass-through traffic is never locked and keeps its address
  a_r7_passthru_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !in_alias && !s_lock) |-> (s_addr == m_addr && s_req));

  // R4: alias read data carries only bit 0
  a_r4_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we && in_alias && m_ready) |-> (m_rdata[31:1] == 31'd0));
endmodule

bind bitband_xlate bb_xlate_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_req   (m_req),
  .m_we    (m_we),
  .m_addr  (m_addr),
  .m_ready (m_ready),
  .m_rdata (m_rdata),
  .s_req   (s_req),
  .s_we    (s_we),
  .s_addr  (s_addr),
  .s_wdata (s_wdata),
  .s_lock  (s_lock),
  .s_ready (s_ready),
  .s_rdata (s_rdata)
);

// File: tb/test_bitband_xlate.sv
module test_bitband_xlate;
  logic        clk;
  logic        rst_n;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic        m_ready;
  logic [31:0] m_rdata;
  logic        s_req, s_we, s_lock, s_ready;
  logic [31:0] s_addr, s_wdata, s_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit stall  = 0;

  logic [31:0] mem     [0:1023];
  logic [31:0] exp_mem [0:1023];
  int          hs_cnt = 0;
  int          hs_base = 0;
  logic [31:0] hs_addr [0:3];
  logic        hs_we   [0:3];

  bitband_xlate i_bitband_xlate (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int widx(input logic [31:0] a);
    return int'({a[30:29], a[9:2]});
  endfunction

  assign s_ready = stall ? (cyc % 3 == 1) : 1'b1;
  assign s_rdata = mem[widx(s_addr)];

  // slave model and handshake log
  always @(posedge clk) begin
    cyc++;
    if (rst_n && s_req && s_ready) begin
      if (hs_cnt - hs_base < 4) begin
        hs_addr[hs_cnt - hs_base] = s_addr;
        hs_we[hs_cnt - hs_base]   = s_we;
      end
      if (s_we) mem[widx(s_addr)] = s_wdata;
      hs_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle monitor, off the clock edge (R7)
  always begin
    @(negedge clk);
    #1;
    if (rst_n && cyc > 4) begin
      if (s_req && s_lock && !s_we)
        chk(!m_ready, "R7", "ready during locked read", {31'd0, m_ready}, 32'd0);
      if (m_req && !is_alias(m_addr))
        chk(!s_lock, "R7", "lock on pass-through", {31'd0, s_lock}, 32'd0);
      if (m_req && m_we && is_alias(m_addr) && s_req)
        chk(s_lock, "R7", "lock during alias write", {31'd0, s_lock}, 32'd1);
    end
  end

  function automatic bit is_alias(input logic [31:0] a);
    return (a >= 32'h2200_0000 && a < 32'h2400_0000) ||
           (a >= 32'h4200_0000 && a < 32'h4400_0000);
  endfunction

  // spec formula, computed arithmetically
  task automatic map_alias(input logic [31:0] a, output logic [31:0] word, output int b);
    logic [31:0] off, byte_a;
    if (a < 32'h3000_0000) begin
      off = a - 32'h2200_0000; byte_a = 32'h2000_0000 + off / 32;
    end else begin
      off = a - 32'h4200_0000; byte_a = 32'h4000_0000 + off / 32;
    end
    b    = int'((off % 32) / 4 + 8 * (byte_a % 4));
    word = byte_a - (byte_a % 4);
  endtask

  task automatic xfer(input bit we, input logic [31:0] a, input logic [31:0] wd,
                      input string req);
    logic [31:0] rd, word, exp_rd;
    int b, n, waited;
    bit al;
    al = is_alias(a);
    word = a; b = 0;
    if (al) map_alias(a, word, b);
    exp_rd = al ? {31'd0, exp_mem[widx(word)][b]} : exp_mem[widx(a)];
    @(negedge clk);
    m_req = 1; m_we = we; m_addr = a; m_wdata = wd;
    hs_base = hs_cnt;
    waited = 0;
    forever begin
      #1;
      if (m_ready) break;
      @(negedge clk);
      waited++;
      if (waited > 60) begin
        chk(0, req, "transfer timeout", 32'(waited), 32'd60);
        break;
      end
    end
    rd = m_rdata;
    @(negedge clk);
    m_req = 0; m_we = 0;
    n = hs_cnt - hs_base;
    if (al && !we) begin
      chk(rd == exp_rd, req, "alias read data", rd, exp_rd);
      chk(n == 1 && !hs_we[0], "R4", "alias read slave transfers", 32'(n), 32'd1);
      chk(hs_addr[0] == word, req, "alias read word address", hs_addr[0], word);
    end else if (al) begin
      exp_mem[widx(word)][b] = wd[0];
      chk(n == 2, "R5", "alias write transfer count", 32'(n), 32'd2);
      chk(!hs_we[0] && hs_we[1], "R5", "read then write order",
          {30'd0, hs_we[1], hs_we[0]}, 32'd2);
      chk(hs_addr[0] == word && hs_addr[1] == word, req, "rmw word address",
          hs_addr[1], word);
      chk(mem[widx(word)] == exp_mem[widx(word)], req, "word after rmw (R5 R6)",
          mem[widx(word)], exp_mem[widx(word)]);
    end else begin
      if (we) exp_mem[widx(a)] = wd;
      else chk(rd == exp_rd, "R1", "pass-through read data", rd, exp_rd);
      chk(n == 1, "R1", "pass-through transfer count", 32'(n), 32'd1);
      chk(hs_addr[0] == a && hs_we[0] == we, "R1", "pass-through address", hs_addr[0], a);
      chk(mem[widx(a)] == exp_mem[widx(a)], "R1", "pass-through word",
          mem[widx(a)], exp_mem[widx(a)]);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]     = 32'h9E37_79B9 * (i + 1);
      exp_mem[i] = mem[i];
    end
    m_req = 0; m_we = 0; m_addr = 0; m_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk(!s_req && !s_lock, "R8", "idle after reset", {30'd0, s_req, s_lock}, 32'd0);

    // R1 pass-through in and out of backing areas
    xfer(0, 32'h2000_0010, 0, "R1");
    xfer(1, 32'h4000_0020, 32'hCAFE_F00D, "R1");
    xfer(0, 32'h4000_0020, 0, "R1");
    xfer(0, 32'h1000_0040, 0, "R1");
    xfer(1, 32'h6000_0100, 32'h1234_5678, "R1");

    // R2 SRAM alias: word 0x20000200 bit 7, byte 0x201 bit 3 -> bit 11, byte 0x203 bit 7 -> bit 31
    xfer(0, 32'h2200_401C, 0, "R2");
    xfer(1, 32'h2200_401C, 32'h0, "R2");
    xfer(0, 32'h2200_401C, 0, "R2");
    xfer(1, 32'h2200_402C, 32'hFFFF_FFFF, "R2");
    xfer(0, 32'h2200_402C, 0, "R2");
    xfer(1, 32'h2200_407C, 32'h0000_0001, "R2");
    xfer(1, 32'h2200_0000, 32'hFFFF_FFFE, "R6");
    xfer(1, 32'h2200_0004, 32'hAAAA_AAAB, "R6");

    // R3 peripheral alias
    xfer(0, 32'h4200_0400, 0, "R3");
    xfer(1, 32'h4200_0404, 32'h0, "R3");
    xfer(1, 32'h4200_047C, 32'h1, "R3");
    xfer(0, 32'h4200_047C, 0, "R3");

    // slave wait states
    stall = 1;
    xfer(1, 32'h2200_4010, 32'h1, "R5");
    xfer(0, 32'h2200_4010, 0, "R4");
    xfer(1, 32'h4200_0840, 32'hFFFF_FFFE, "R6");
    xfer(0, 32'h4000_0020, 0, "R1");
    xfer(1, 32'h2000_0030, 32'h0BAD_BEEF, "R1");
    stall = 0;

    for (int i = 0; i < 1024; i++)
      if (mem[i] !== exp_mem[i])
        chk(0, "R5", "final memory image", mem[i], exp_mem[i]);
    checks++;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule